// File: doc/BRIEF.md
# Balanced knock energy integrator

This block is the digital back end of an engine knock detector. Each clock cycle it may accept one pair of rectified magnitudes, one from the knock band and one from the background (reference) band. One of the two passes at unity gain. The other is scaled down by a programmable balance gain, and a single control bit picks which one that is. The block adds the weighted difference, knock minus reference, to a saturating fixed-point accumulator. Each sample's contribution is scaled by the reciprocal of a programmable time constant, so a steady difference of one unit moves the output by one unit per time constant.

An external mode input sets the phases of a measurement window. A rising edge starts a settle phase, during which the accumulator is forced to a fixed reset level. Integration follows. After a falling edge, integration continues for a short drain interval, and then the block holds its output until the next rising edge. The first window after reset only primes the block, so its result is marked as not valid.

The phase machine has five states. IDLE is the state after reset. PRELOAD is entered on a rising edge of the mode input from any state, and the counter restarts. PRELOAD moves to INTEG after SETTLE_CYC cycles, or to DRAIN if the mode input falls first. INTEG moves to DRAIN on a falling edge. DRAIN moves to HOLD after HOLD_CYC cycles. HOLD stays put until the next rising edge.

Top module: `knock_integrator`

## Requirements
- R1: The unity-gain channel reaches the difference unchanged, and the scaled channel is never larger than its input. With gain code 0 both channels pass unchanged, so equal magnitudes leave the output at the reset level.
- R2: For gain code c (6 bits, 0..63), the scaled magnitude is floor(m*G/2^GAIN_FRAC), where G = round(126*2^GAIN_FRAC/(126+13c)). This gives 1.000 at code 0 and about 0.133 at code 63.
- R3: When atten_sel is 0, the knock magnitude is scaled and the reference passes unchanged. When atten_sel is 1, the reference is scaled and the knock passes unchanged.
- R4: Each accepted sample adds (knock_eff - ref_eff)*Rc to the accumulator, where Rc = round(2^ACC_FRAC/(TC_MIN_CYC + t*TC_STEP_CYC)) for time-constant code t (5 bits, 0..31). The output int_value is the accumulator shifted right by ACC_FRAC, so a positive difference raises it.
- R5: A rising edge of mode_in forces the accumulator to RESET_LVL for the next SETTLE_CYC cycles. Samples that arrive in that interval are ignored, and integration starts after it.
- R6: After mode_in falls, samples are still accepted for HOLD_CYC cycles, counting from the edge where the low level is seen. After that, int_value is frozen and samples are ignored until the next rising edge.
- R7: The accumulator saturates: int_value stops at 0 and at 2^OUT_W-1 and never wraps.
- R8: result_ok is 0 after reset and stays 0 through the hold of the first window. It is 1 in the hold of every later window, and it returns to 0 on the next rising edge of mode_in.
- R9: After reset, int_value equals RESET_LVL and result_ok is 0. Samples are ignored until the first rising edge of mode_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| knock_mag | input | MAG_W | Rectified knock-band magnitude |
| ref_mag | input | MAG_W | Rectified reference-band magnitude |
| mag_valid | input | 1 | The magnitude pair is valid this cycle |
| gain_code | input | 6 | Balance gain code |
| atten_sel | input | 1 | 0 scales knock, 1 scales reference |
| tc_code | input | 5 | Integrator time-constant code |
| mode_in | input | 1 | High integrates, low holds |
| int_value | output | OUT_W | Integer part of the accumulator |
| result_ok | output | 1 | The held result comes from a valid window |

## Verification
The bench builds the block with the default widths, a 12-bit output, 10 gain fraction bits, 20 accumulator fraction bits and a 160 to 2392 cycle time-constant range. With time-constant code 0 and full-scale inputs, a few hundred samples are enough to drive the output into both saturation limits. SETTLE_CYC and HOLD_CYC are both reduced to 16, so many complete windows fit into a short run. The short intervals also make the preload, drain and hold edges easy to probe with samples placed right beside them.

// File: rtl/knock_integ_pkg.sv
package knock_integ_pkg;

    localparam int GAIN_CODE_W = 6;
    localparam int TC_CODE_W   = 5;
    localparam int GAIN_N      = 1 << GAIN_CODE_W;
    localparam int TC_N        = 1 << TC_CODE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRELOAD,
        PH_INTEG,
        PH_DRAIN,
        PH_HOLD
    } phase_t;

    // Balance multiplier: round(126 * 2^frac / (126 + 13*code))
    function automatic longint gain_word(input int code, input int frac);
        longint den;
        den = 126 + 13 * longint'(code);
        return ((longint'(126) << (frac + 1)) + den) / (2 * den);
    endfunction

    // Time-constant reciprocal: round(2^frac / (tc_min + code*tc_step))
    function automatic longint recip_word(input int code, input int tc_min,
                                          input int tc_step, input int frac);
        longint den;
        den = longint'(tc_min) + longint'(code) * longint'(tc_step);
        return ((longint'(1) << (frac + 1)) + den) / (2 * den);
    endfunction

endpackage

// File: rtl/knock_balance.sv
module knock_balance
    import knock_integ_pkg::*;
#(
    parameter int MAG_W     = 12,
    parameter int GAIN_FRAC = 10
) (
    input  logic [MAG_W-1:0]       knock_mag,
    input  logic [MAG_W-1:0]       ref_mag,
    input  logic [GAIN_CODE_W-1:0] gain_code,
    input  logic                   atten_sel,
    output logic [MAG_W-1:0]       knock_eff,
    output logic [MAG_W-1:0]       ref_eff
);

    localparam int GW = GAIN_FRAC + 1;
    localparam int PW = MAG_W + GW;

    logic [GW-1:0]    gain_rom [GAIN_N];
    logic [GW-1:0]    gain_q;
    logic [MAG_W-1:0] target;
    logic [PW-1:0]    prod;
    logic [MAG_W-1:0] scaled;

    for (genvar c = 0; c < GAIN_N; c++) begin : g_gain_rom
        assign gain_rom[c] = GW'(gain_word(c, GAIN_FRAC));
    end

    assign gain_q = gain_rom[gain_code];

    // a single multiplier serves whichever channel is attenuated
    assign target = atten_sel ? ref_mag : knock_mag;
    assign prod   = target * gain_q;
    assign scaled = MAG_W'(prod >> GAIN_FRAC);

    assign knock_eff = atten_sel ? knock_mag : scaled;
    assign ref_eff   = atten_sel ? scaled : ref_mag;

endmodule

// File: rtl/knock_accum.sv
module knock_accum
    import knock_integ_pkg::*;
#(
    parameter int MAG_W       = 12,
    parameter int ACC_FRAC    = 20,
    parameter int OUT_W       = 12,
    parameter int TC_MIN_CYC  = 160,
    parameter int TC_STEP_CYC = 72,
    parameter int RESET_LVL   = 410
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAG_W-1:0]     knock_eff,
    input  logic [MAG_W-1:0]     ref_eff,
    input  logic [TC_CODE_W-1:0] tc_code,
    input  logic                 preload,
    input  logic                 integ,
    output logic [OUT_W-1:0]     acc_out
);

    localparam int ACC_W   = OUT_W + ACC_FRAC;
    localparam int RECIP_W = ACC_FRAC + 1;
    localparam int STEP_W  = (MAG_W + 1) + (RECIP_W + 1);
    localparam int SUM_W   = ((STEP_W > ACC_W) ? STEP_W : ACC_W) + 2;
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_RST = ACC_W'(RESET_LVL) << ACC_FRAC;
    localparam logic signed [SUM_W-1:0] SUM_MAX =
        $signed({{(SUM_W-ACC_W){1'b0}}, ACC_MAX});

    logic [RECIP_W-1:0]       recip_rom [TC_N];
    logic [RECIP_W-1:0]       recip_q;
    logic signed [MAG_W:0]    diff_w;
    logic signed [STEP_W-1:0] step_w;
    logic signed [SUM_W-1:0]  sum_w;
    logic [ACC_W-1:0]         acc_d;
    logic [ACC_W-1:0]         acc_q;

    for (genvar c = 0; c < TC_N; c++) begin : g_recip_rom
        assign recip_rom[c] = RECIP_W'(recip_word(c, TC_MIN_CYC, TC_STEP_CYC, ACC_FRAC));
    end

    assign recip_q = recip_rom[tc_code];
    assign diff_w  = $signed({1'b0, knock_eff}) - $signed({1'b0, ref_eff});
    assign step_w  = diff_w * $signed({1'b0, recip_q});
    assign sum_w   = $signed({{(SUM_W-ACC_W){1'b0}}, acc_q})
                   + $signed({{(SUM_W-STEP_W){step_w[STEP_W-1]}}, step_w});

    always_comb begin
        if (sum_w[SUM_W-1]) begin
            acc_d = '0;
        end else if (sum_w > SUM_MAX) begin
            acc_d = ACC_MAX;
        end else begin
            acc_d = sum_w[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_RST;
        end else if (preload) begin
            acc_q <= ACC_RST;
        end else if (integ) begin
            acc_q <= acc_d;
        end
    end

    assign acc_out = acc_q[ACC_W-1:ACC_FRAC];

    // R4: a knock excess raises the accumulator unless it is pinned at the top
    assert_knock_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (integ && !preload && (knock_eff > ref_eff) && (acc_q != ACC_MAX))
        |=> (acc_q > $past(acc_q)));

    // R7: the upper limit holds against a non-negative difference
    assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (integ && !preload && (acc_q == ACC_MAX) && (knock_eff >= ref_eff))
        |=> (acc_q == ACC_MAX));

    // R7: the lower limit holds against a non-positive difference
    assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (integ && !preload && (acc_q == '0) && (knock_eff <= ref_eff))
        |=> (acc_q == '0));

endmodule

// File: rtl/knock_phase_fsm.sv
module knock_phase_fsm
    import knock_integ_pkg::*;
#(
    parameter int SETTLE_CYC = 80,
    parameter int HOLD_CYC   = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    output logic preload,
    output logic integ_win,
    output logic result_ok
);

    localparam int MAX_CYC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mode_q;
    logic             rise, fall;
    logic             first_q;
    logic             ok_q;

    assign rise = mode_in & ~mode_q;
    assign fall = ~mode_in & mode_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rise) begin
            state_d = PH_PRELOAD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                end
                PH_PRELOAD: begin
                    if (fall) begin
                        state_d = PH_DRAIN;
                        cnt_d   = '0;
                    end else if (cnt_q == SETTLE_LAST) begin
                        state_d = PH_INTEG;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_INTEG: begin
                    if (fall) begin
                        state_d = PH_DRAIN;
                        cnt_d   = '0;
                    end
                end
                PH_DRAIN: begin
                    if (cnt_q == HOLD_LAST) begin
                        state_d = PH_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            mode_q  <= mode_in;
        end
    end

    // registered outputs: result validity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q    <= 1'b0;
            first_q <= 1'b1;
        end else if (rise) begin
            ok_q <= 1'b0;
        end else if ((state_q == PH_DRAIN) && (state_d == PH_HOLD)) begin
            ok_q    <= ~first_q;
            first_q <= 1'b0;
        end
    end

    always_comb begin
        preload   = (state_q == PH_PRELOAD);
        integ_win = (state_q == PH_INTEG) || (state_q == PH_DRAIN);
        result_ok = ok_q;
    end

    // R8: a valid flag is only ever shown while holding
    assert_flag_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q |-> (state_q == PH_HOLD));

    // R5: a rising mode edge always lands in the settle phase
    assert_rise_preload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_in) |=> (state_q == PH_PRELOAD));

    // R5: the settle counter never runs past its interval
    assert_settle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_PRELOAD) |-> (cnt_q <= SETTLE_LAST));

endmodule

// File: rtl/knock_integrator.sv
module knock_integrator
    import knock_integ_pkg::*;
#(
    parameter int MAG_W       = 12,
    parameter int GAIN_FRAC   = 10,
    parameter int ACC_FRAC    = 20,
    parameter int OUT_W       = 12,
    parameter int TC_MIN_CYC  = 160,
    parameter int TC_STEP_CYC = 72,
    parameter int RESET_LVL   = 410,
    parameter int SETTLE_CYC  = 80,
    parameter int HOLD_CYC    = 80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MAG_W-1:0]       knock_mag,
    input  logic [MAG_W-1:0]       ref_mag,
    input  logic                   mag_valid,
    input  logic [GAIN_CODE_W-1:0] gain_code,
    input  logic                   atten_sel,
    input  logic [TC_CODE_W-1:0]   tc_code,
    input  logic                   mode_in,
    output logic [OUT_W-1:0]       int_value,
    output logic                   result_ok
);

    logic [MAG_W-1:0] knock_eff;
    logic [MAG_W-1:0] ref_eff;
    logic             preload_w;
    logic             integ_win_w;
    logic             integ_w;

    knock_phase_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (mode_in),
        .preload   (preload_w),
        .integ_win (integ_win_w),
        .result_ok (result_ok)
    );

    knock_balance #(
        .MAG_W     (MAG_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_balance (
        .knock_mag (knock_mag),
        .ref_mag   (ref_mag),
        .gain_code (gain_code),
        .atten_sel (atten_sel),
        .knock_eff (knock_eff),
        .ref_eff   (ref_eff)
    );

    assign integ_w = integ_win_w & mag_valid;

    knock_accum #(
        .MAG_W       (MAG_W),
        .ACC_FRAC    (ACC_FRAC),
        .OUT_W       (OUT_W),
        .TC_MIN_CYC  (TC_MIN_CYC),
        .TC_STEP_CYC (TC_STEP_CYC),
        .RESET_LVL   (RESET_LVL)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .knock_eff (knock_eff),
        .ref_eff   (ref_eff),
        .tc_code   (tc_code),
        .preload   (preload_w),
        .integ     (integ_w),
        .acc_out   (int_value)
    );

    // R1: balancing never amplifies either channel
    assert_no_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (knock_eff <= knock_mag) && (ref_eff <= ref_mag));

    // R2: code zero is unity on both channels
    assert_code0_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code == '0) |-> ((knock_eff == knock_mag) && (ref_eff == ref_mag)));

    // R3: the unselected channel passes untouched
    assert_unity_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
        atten_sel ? (knock_eff == knock_mag) : (ref_eff == ref_mag));

    // R6: outside settle and integration the output cannot move
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!integ_win_w && !preload_w) |=> $stable(int_value));

endmodule

// File: tb/knock_integrator_tb_top.sv
module knock_integrator_tb_top;

    localparam int MAG_W       = 12;
    localparam int GAIN_FRAC   = 10;
    localparam int ACC_FRAC    = 20;
    localparam int OUT_W       = 12;
    localparam int TC_MIN_CYC  = 160;
    localparam int TC_STEP_CYC = 72;
    localparam int RESET_LVL   = 410;
    localparam int SETTLE_CYC  = 16;
    localparam int HOLD_CYC    = 16;
    localparam int MAG_MAX     = (1 << MAG_W) - 1;
    localparam longint ACC_TOP = (longint'(1) << (OUT_W + ACC_FRAC)) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [MAG_W-1:0] knock_mag;
    logic [MAG_W-1:0] ref_mag;
    logic             mag_valid;
    logic [5:0]       gain_code;
    logic             atten_sel;
    logic [4:0]       tc_code;
    logic             mode_in;
    logic [OUT_W-1:0] int_value;
    logic             result_ok;

    int     total = 0;
    int     bad = 0;
    bit     done = 0;
    longint m_acc;

    always #10 clk = ~clk;

    knock_integrator #(
        .MAG_W       (MAG_W),
        .GAIN_FRAC   (GAIN_FRAC),
        .ACC_FRAC    (ACC_FRAC),
        .OUT_W       (OUT_W),
        .TC_MIN_CYC  (TC_MIN_CYC),
        .TC_STEP_CYC (TC_STEP_CYC),
        .RESET_LVL   (RESET_LVL),
        .SETTLE_CYC  (SETTLE_CYC),
        .HOLD_CYC    (HOLD_CYC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .knock_mag (knock_mag),
        .ref_mag   (ref_mag),
        .mag_valid (mag_valid),
        .gain_code (gain_code),
        .atten_sel (atten_sel),
        .tc_code   (tc_code),
        .mode_in   (mode_in),
        .int_value (int_value),
        .result_ok (result_ok)
    );

    function automatic longint exp_gain(input int c);
        longint den = 126 + 13 * longint'(c);
        return ((longint'(126) * (longint'(1) << GAIN_FRAC)) * 2 + den) / (2 * den);
    endfunction

    function automatic longint exp_recip(input int c);
        longint den = longint'(TC_MIN_CYC) + longint'(c) * TC_STEP_CYC;
        return ((longint'(1) << ACC_FRAC) * 2 + den) / (2 * den);
    endfunction

    task automatic model_step(input int k, input int r);
        longint g = exp_gain(int'(gain_code));
        longint ke = atten_sel ? longint'(k) : (longint'(k) * g) >>> GAIN_FRAC;
        longint re = atten_sel ? (longint'(r) * g) >>> GAIN_FRAC : longint'(r);
        m_acc = m_acc + (ke - re) * exp_recip(int'(tc_code));
        if (m_acc < 0) m_acc = 0;
        if (m_acc > ACC_TOP) m_acc = ACC_TOP;
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pick(input int kind, input int kv, input int rv,
                        output int k, output int r);
        case (kind)
            1: begin k = kv; r = rv; end
            2: begin k = int'($urandom_range(0, MAG_MAX)); r = k; end
            default: begin
                k = int'($urandom_range(0, MAG_MAX));
                r = int'($urandom_range(0, MAG_MAX));
            end
        endcase
    endtask

    // one full window; codes are held for its duration
    task automatic run_window(input int g, input bit sel, input int t, input int n,
                              input int kind, input int kv, input int rv,
                              input int drain_n, input bit exp_ok, input string tag);
        int k, r;
        gain_code = 6'(g);
        atten_sel = sel;
        tc_code   = 5'(t);
        m_acc     = longint'(RESET_LVL) << ACC_FRAC;
        // samples at the rising edge and through the settle phase are ignored
        mode_in   = 1'b1;
        mag_valid = 1'b1;
        knock_mag = '0;
        ref_mag   = MAG_W'(MAG_MAX);
        repeat (SETTLE_CYC) @(negedge clk);
        mag_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 settle level", int_value, RESET_LVL);
        check("R8 flag cleared on rise", result_ok, 0);
        for (int i = 0; i < n; i++) begin
            pick(kind, kv, rv, k, r);
            knock_mag = MAG_W'(k);
            ref_mag   = MAG_W'(r);
            mag_valid = 1'b1;
            model_step(k, r);
            @(negedge clk);
        end
        mag_valid = 1'b0;
        mode_in   = 1'b0;
        for (int i = 0; i < drain_n; i++) begin
            pick(kind, kv, rv, k, r);
            knock_mag = MAG_W'(k);
            ref_mag   = MAG_W'(r);
            mag_valid = 1'b1;
            model_step(k, r);
            @(negedge clk);
        end
        mag_valid = 1'b0;
        repeat (HOLD_CYC + 3) @(negedge clk);
        check(tag, int_value, m_acc >>> ACC_FRAC);
        check("R8 result flag", result_ok, exp_ok);
    endtask

    initial begin : main
        int held;
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        mode_in   = 1'b0;
        mag_valid = 1'b0;
        knock_mag = '0;
        ref_mag   = '0;
        gain_code = '0;
        atten_sel = 1'b0;
        tc_code   = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset level", int_value, RESET_LVL);
        check("R9 reset flag", result_ok, 0);

        // R9: samples before any rising edge are ignored
        knock_mag = MAG_W'(4000);
        ref_mag   = '0;
        mag_valid = 1'b1;
        repeat (20) @(negedge clk);
        mag_valid = 1'b0;
        @(negedge clk);
        check("R9 idle ignores samples", int_value, RESET_LVL);

        // first window primes only (R8), random data, knock attenuated (R4)
        run_window(20, 1'b0, 5, 100, 0, 0, 0, 0, 1'b0, "R4 first window value");
        // reference attenuated at code 63 and slowest constant (R2, R3)
        run_window(63, 1'b1, 31, 120, 1, 1000, 2000, 0, 1'b1, "R2 R3 ref scaled");
        // knock attenuated at code 40 (R3)
        run_window(40, 1'b0, 10, 80, 1, 3000, 500, 0, 1'b1, "R3 knock scaled");
        // unity code, equal inputs leave the reset level (R1)
        run_window(0, 1'b0, 0, 60, 2, 0, 0, 0, 1'b1, "R1 unity balance");
        check("R1 unity exact", int_value, RESET_LVL);
        // upward saturation (R7)
        run_window(63, 1'b1, 0, 300, 1, MAG_MAX, MAG_MAX, 0, 1'b1, "R7 high value");
        check("R7 top limit", int_value, (1 << OUT_W) - 1);

        // R6: hold ignores samples and keeps the value
        held = int'(int_value);
        knock_mag = '0;
        ref_mag   = MAG_W'(MAG_MAX);
        mag_valid = 1'b1;
        repeat (50) @(negedge clk);
        mag_valid = 1'b0;
        @(negedge clk);
        check("R6 hold frozen", int_value, held);
        check("R8 flag kept in hold", result_ok, 1);

        // downward saturation (R7)
        run_window(63, 1'b0, 0, 300, 1, MAG_MAX, MAG_MAX, 0, 1'b1, "R7 low value");
        check("R7 bottom limit", int_value, 0);
        // drain samples after the falling edge still count (R6)
        run_window(10, 1'b0, 3, 40, 1, 2500, 100, 4, 1'b1, "R6 drain samples");

        // random code mixes
        for (int w = 0; w < 8; w++) begin
            run_window(int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)),
                       int'($urandom_range(0, 31)), int'($urandom_range(20, 150)),
                       0, 0, 0, int'($urandom_range(0, 4)), 1'b1, "R4 random window");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule